// File: doc/BRIEF.md
# Nibble-Wide Serial Write Slave

This block is the receive side of a fast configuration link. It takes write transactions from a host on a four-bit data bus. The bus is framed by an active-low chip select and paced by a host serial clock. The block runs on a local clock `clk` that is fast enough to oversample the serial lines. The serial inputs must already be synchronous to `clk` when they arrive. On each rising edge of the serial clock inside a frame, the block accepts one nibble.

The first four nibbles form a header. The header holds a direction flag, a sync-request flag and a 14-bit start address. After the header, every pair of nibbles forms one data byte. Each completed byte is presented immediately as a one-cycle write strobe, together with its address and data. After each byte the address counts down by one. When chip select is released, the block issues a single sync pulse if both of these hold: the header asked for a sync, and at least one byte was written in the frame. A downstream register file would take the strobes and apply the sync.

Top module: `nibble_wr_slave`

## Requirements
- R1: One nibble is taken from `ser_dat` on each rising edge of `ser_clk` while `ser_cs_n` is low. A rising edge is seen as `ser_clk` high in a `clk` sample after a low sample.
- R2: The header uses the first four nibbles of a frame. In the first nibble, bit 3 is the direction flag (0 = write, 1 = read), bit 2 is the sync flag, and bits 1:0 are address bits 13:12. Nibbles two to four carry address bits 11:8, 7:4 and 3:0, in that order.
- R3: A data byte is its first nibble in bits 7:4 and its second nibble in bits 3:0. `wr_en` is high for exactly one `clk` cycle, starting the cycle after the sample that captured the second nibble. During that cycle `wr_addr` and `wr_data` hold that byte's address and value.
- R4: The first byte of a frame goes to the header address. Each later byte goes to the previous address minus one, and 0x0000 steps down to 0x3FFF.
- R5: A frame whose direction flag is 1 produces no write strobe and no sync pulse.
- R6: `sync_pulse` is high for exactly one `clk` cycle. It starts the cycle after the first sample of `ser_cs_n` high that follows a low sample. It fires only if the frame's sync flag was 1 and the frame wrote at least one byte.
- R7: A frame released before its first data byte is complete produces no sync pulse, even if its sync flag is set.
- R8: A byte left half-received when `ser_cs_n` rises is dropped with no strobe. The next frame starts again with a header.
- R9: After `rst_n` is released, and before any frame, `wr_en` and `sync_pulse` are 0.
- R10: `ser_clk` edges while `ser_cs_n` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Host serial clock, already synchronous to clk |
| ser_cs_n | input | 1 | Active-low frame select |
| ser_dat | input | 4 | Nibble data bus |
| wr_en | output | 1 | One-cycle byte write strobe |
| wr_addr | output | 14 | Address of the strobed byte |
| wr_data | output | 8 | Value of the strobed byte |
| sync_pulse | output | 1 | One-cycle sync request at frame release |

## Verification
A wrong nibble count or a misaligned half-byte flag would show up at the ports as wrongly placed strobes or nibble-swapped data. This appears on the first data byte of the next frame, one `clk` cycle after the offending serial edge. A wrong address register would show up as a wrong `wr_addr` on the very next strobe. A stale sync or direction flag carried over from an earlier frame would show up one cycle after chip select is released, as an unwanted or missing `sync_pulse`. The bench's reference model therefore compares every strobe and every sync cycle. It runs this comparison across partial frames, read frames, address wrap and idle clock toggles.

// File: rtl/nibble_wr_slave.sv
module nibble_wr_slave (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_cs_n,
  input  logic [3:0]  ser_dat,
  output logic        wr_en,
  output logic [13:0] wr_addr,
  output logic [7:0]  wr_data,
  output logic        sync_pulse
);
  localparam int HDR_NIBS = 4;

  logic        sclk_q, cs_q;
  logic [2:0]  hcnt;
  logic        half, is_rd, want_sync, got_byte;
  logic [3:0]  hi_nib;
  logic [13:0] addr;

  wire nib_tick = ser_clk & ~sclk_q & ~ser_cs_n;
  wire in_hdr   = hcnt != 3'(HDR_NIBS);
  wire release_ev = ser_cs_n & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      hcnt       <= '0;
      half       <= 1'b0;
      is_rd      <= 1'b0;
      want_sync  <= 1'b0;
      got_byte   <= 1'b0;
      hi_nib     <= '0;
      addr       <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      sync_pulse <= 1'b0;
    end else begin
      sclk_q     <= ser_clk;
      cs_q       <= ser_cs_n;
      wr_en      <= 1'b0;
      sync_pulse <= release_ev & want_sync & ~is_rd & got_byte;
      if (ser_cs_n) begin
        hcnt      <= '0;
        half      <= 1'b0;
        is_rd     <= 1'b0;
        want_sync <= 1'b0;
        got_byte  <= 1'b0;
      end else if (nib_tick) begin
        if (in_hdr) begin
          hcnt <= hcnt + 3'd1;
          if (hcnt == 3'd0) begin
            is_rd     <= ser_dat[3];
            want_sync <= ser_dat[2];
            addr      <= {ser_dat[1:0], 12'h000};
          end else begin
            addr[11:0] <= {addr[7:0], ser_dat};
          end
        end else if (!half) begin
          hi_nib <= ser_dat;
          half   <= 1'b1;
        end else begin
          half <= 1'b0;
          if (!is_rd) begin
            wr_en    <= 1'b1;
            wr_addr  <= addr;
            wr_data  <= {hi_nib, ser_dat};
            addr     <= addr - 14'd1;
            got_byte <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/nibble_wr_slave_chk.sv
module nibble_wr_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ser_cs_n,
  input logic        wr_en,
  input logic [13:0] wr_addr,
  input logic        sync_pulse
);
  logic        have_last, seen_byte, cs_q;
  logic [13:0] last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      seen_byte <= 1'b0;
      cs_q      <= 1'b1;
      last_addr <= '0;
    end else begin
      cs_q <= ser_cs_n;
      if (ser_cs_n) have_last <= 1'b0;
      else if (wr_en) begin
        have_last <= 1'b1;
        last_addr <= wr_addr;
      end
      if (ser_cs_n && cs_q) seen_byte <= 1'b0;
      else if (wr_en) seen_byte <= 1'b1;
    end
  end

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && have_last && !ser_cs_n) |-> (wr_addr == last_addr - 14'd1));
  assert_sync_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);
  assert_sync_at_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> ($past(ser_cs_n) && !$past(ser_cs_n, 2)));
  assert_sync_needs_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> seen_byte);
  assert_no_write_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(ser_cs_n));
endmodule

bind nibble_wr_slave nibble_wr_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n),
  .wr_en(wr_en), .wr_addr(wr_addr), .sync_pulse(sync_pulse)
);

// File: tb/sim_nibble_wr_slave.sv
module sim_nibble_wr_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_cs_n = 1'b1;
  logic [3:0] ser_dat = '0;
  logic wr_en, sync_pulse;
  logic [13:0] wr_addr;
  logic [7:0] wr_data;

  always #2.5 clk = ~clk;

  nibble_wr_slave u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_cs_n(ser_cs_n),
    .ser_dat(ser_dat), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_pulse(sync_pulse)
  );

  int checks = 0, fails = 0, cycles = 0;
  int n_wr = 0, n_sync = 0;
  logic [13:0] last_addr;
  logic [7:0] last_data;

  // behavioural reference model
  logic [3:0] q[$];
  logic m_sclk = 1'b0, m_cs = 1'b1;
  logic exp_wr = 1'b0, exp_sync = 1'b0;
  logic [13:0] exp_addr = '0;
  logic [7:0] exp_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_sclk = 1'b0; m_cs = 1'b1;
      exp_wr = 1'b0; exp_sync = 1'b0;
    end else begin
      exp_wr = 1'b0;
      exp_sync = ser_cs_n && !m_cs && (q.size() >= 6) && !q[0][3] && q[0][2];
      if (ser_cs_n) q.delete();
      else if (ser_clk && !m_sclk) begin
        q.push_back(ser_dat);
        if (q.size() > 4 && ((q.size() - 4) % 2 == 0) && !q[0][3]) begin
          int k;
          logic [13:0] base;
          k = (q.size() - 4) / 2;
          base = {q[0][1:0], q[1], q[2], q[3]};
          exp_wr = 1'b1;
          exp_addr = base - 14'(k - 1);
          exp_data = {q[q.size()-2], q[q.size()-1]};
        end
      end
      m_sclk = ser_clk; m_cs = ser_cs_n;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R3 strobe", 32'(wr_en), 32'(exp_wr));
      if (exp_wr) begin
        chk("R4 address", 32'(wr_addr), 32'(exp_addr));
        chk("R3 data", 32'(wr_data), 32'(exp_data));
      end
      chk("R6 sync", 32'(sync_pulse), 32'(exp_sync));
      if (wr_en) begin n_wr++; last_addr = wr_addr; last_data = wr_data; end
      if (sync_pulse) n_sync++;
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic nib(input logic [3:0] d);
    @(negedge clk); ser_dat = d; ser_clk = 1'b0;
    @(negedge clk);
    @(negedge clk); ser_clk = 1'b1;
    @(negedge clk);
  endtask

  task automatic open_frame(input logic rd, input logic sy, input logic [13:0] a);
    @(negedge clk); ser_clk = 1'b0; ser_cs_n = 1'b0;
    @(negedge clk);
    nib({rd, sy, a[13:12]});
    nib(a[11:8]);
    nib(a[7:4]);
    nib(a[3:0]);
  endtask

  task automatic close_frame();
    @(negedge clk); ser_clk = 1'b0;
    @(negedge clk); ser_cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] b);
    nib(b[7:4]);
    nib(b[3:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 wr_en after reset", 32'(wr_en), 0);
    chk("R9 sync after reset", 32'(sync_pulse), 0);

    // R1 R2 R3 R4 R6: write with sync
    n_wr = 0; n_sync = 0;
    open_frame(1'b0, 1'b1, 14'h0123);
    put_byte(8'hA5); put_byte(8'h3C); put_byte(8'hF0);
    close_frame();
    chk("R3 strobe count", 32'(n_wr), 3);
    chk("R4 last address", 32'(last_addr), 32'h0121);
    chk("R2 last data", 32'(last_data), 32'hF0);
    chk("R6 one sync", 32'(n_sync), 1);

    // R4 wrap below zero
    n_wr = 0; n_sync = 0;
    open_frame(1'b0, 1'b0, 14'h0001);
    put_byte(8'h11); put_byte(8'h22); put_byte(8'h33);
    close_frame();
    chk("R4 wrap address", 32'(last_addr), 32'h3FFF);
    chk("R6 no sync without flag", 32'(n_sync), 0);

    // R5 read frame ignored
    n_wr = 0; n_sync = 0;
    open_frame(1'b1, 1'b1, 14'h2222);
    put_byte(8'h5A); put_byte(8'h77);
    close_frame();
    chk("R5 no strobe on read", 32'(n_wr), 0);
    chk("R5 no sync on read", 32'(n_sync), 0);

    // R7 R8: header plus one nibble only, sync requested
    n_wr = 0; n_sync = 0;
    open_frame(1'b0, 1'b1, 14'h3ABC);
    nib(4'h9);
    close_frame();
    chk("R7 no sync before first byte", 32'(n_sync), 0);
    chk("R8 partial byte dropped", 32'(n_wr), 0);

    // R8: two bytes then half a byte, then a fresh frame
    n_wr = 0;
    open_frame(1'b0, 1'b0, 14'h0040);
    put_byte(8'h12); put_byte(8'h34); nib(4'hE);
    close_frame();
    chk("R8 only whole bytes", 32'(n_wr), 2);
    n_wr = 0;
    open_frame(1'b0, 1'b0, 14'h1000);
    put_byte(8'hC3);
    close_frame();
    chk("R8 fresh header address", 32'(last_addr), 32'h1000);
    chk("R8 fresh header data", 32'(last_data), 32'hC3);

    // R10: clock toggles with select high
    n_wr = 0;
    for (int i = 0; i < 12; i++) nib(4'(i));
    chk("R10 no strobe while idle", 32'(n_wr), 0);
    n_wr = 0;
    open_frame(1'b0, 1'b1, 14'h0777);
    put_byte(8'h6D);
    close_frame();
    chk("R10 clean frame after idle address", 32'(last_addr), 32'h0777);
    chk("R10 clean frame after idle data", 32'(last_data), 32'h6D);

    // R1: random frames checked by the model
    for (int f = 0; f < 20; f++) begin
      int nb;
      nb = int'($urandom_range(0, 5));
      open_frame(1'($urandom_range(0, 3) == 0), 1'($urandom), 14'($urandom));
      for (int b = 0; b < nb; b++) put_byte(8'($urandom));
      if ($urandom_range(0, 1) == 1) nib(4'($urandom));
      close_frame();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule